// File: doc/BRIEF.md
# Windowed Service Watchdog

This block is a watchdog counter that runs on the oscillator clock and asks for a system reset when software stops proving that it is alive. Software sets it up through a control register that accepts exactly one write after reset. That write picks one of seven timeout periods or leaves the watchdog off, turns on an optional window mode, and chooses whether the count pauses while a debug-halt input is high.

To keep the system running, software writes the key 0x55 and then the key 0xAA to a service register. The 0xAA write restarts the period from zero. A one-cycle reset request pulse is raised in four cases: the period runs out, a key is written in the wrong order, any other value is written to the service register, or, in window mode, a service write lands before the last quarter of the period. A status output shows when service writes are currently allowed.

The register port is one write strobe, a one-bit address (0 selects the control register, 1 selects the service register), a write byte and a combinational read byte. A parameter scales the base period. With the default it matches oscillator-rate timing, and a bench can shrink it.

Top module: `wdog_win`

## Requirements
- R1: Reading address 0 returns the control byte with window mode at bit 4, debug freeze at bit 3 and rate select at bits 2:0. Bits 7:5 always read as zero, and reading address 1 returns zero.
- R2: Only the first control write after reset is stored. Every later control write leaves the register unchanged.
- R3: While the rate select is zero the counter is stopped. No reset request is ever raised, writes to the service register are ignored, and the window status stays low.
- R4: With rate select n from 1 to 7 the period P is 2^(BASE_SHIFT+2n) clocks. If the watchdog is not serviced, rst_req_o is high for exactly one cycle, P clock edges after the enabling control write, and stays low before that.
- R5: Writing 0x55 and then 0xAA to the service register restarts the period. The next unserviced timeout then comes P edges after the 0xAA write.
- R6: Any value other than 0x55 or 0xAA written to the service register raises rst_req_o in the cycle after the write, and so does 0xAA with no 0x55 before it. This applies while the watchdog is enabled.
- R7: With window mode on, a service write made while the count is below P - P/4 raises rst_req_o in the cycle after the write.
- R8: Inside an open window, 0x55 may be written any number of times before the 0xAA without raising a request.
- R9: With the freeze bit set the count holds while dbg_halt_i is high. With the freeze bit clear the count keeps running during halt.
- R10: win_open_o is high when the watchdog is enabled and either window mode is off or the count is at least P - P/4.
- R11: Reset clears the control register and its write-once lock, forgets any pending 0x55, and reloads the count to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 selects control, 1 selects service register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| dbg_halt_i | input | 1 | Debug halt is active |
| rst_req_o | output | 1 | One-cycle reset request |
| win_open_o | output | 1 | Service writes are currently allowed |

## Verification
The count becomes zero at the clock edge that takes an enabling control write or a valid 0xAA. Each later edge adds one, so the timeout request appears exactly P edges after that write. A key fault or an early window write shows on rst_req_o one edge after the write, because the request is registered. Read data and win_open_o follow the current state with no delay. The bench drives and samples on the falling edge, so after every write it knows the count value. It then checks the request sample by sample: low on every edge before the expected one, high on that edge, and low again on the edge after.

// File: rtl/wdog_win_pkg.sv
package wdog_win_pkg;
  typedef struct packed {
    logic       win;
    logic       frz;
    logic [2:0] rate;
  } ctrl_t;

  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic       SEL_CTRL  = 1'b0;
  localparam logic       SEL_ARM   = 1'b1;
endpackage

// File: rtl/wdog_win_ctrl.sv
module wdog_win_ctrl
  import wdog_win_pkg::*;
#(
  parameter logic [4:0] RST_VAL = 5'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [4:0] wdata_i,
  output ctrl_t      ctrl_o,
  output logic       start_o
);
  ctrl_t ctrl_q;
  logic  locked_q;

  assign ctrl_o  = ctrl_q;
  // accepted write with nonzero rate opens a fresh period
  assign start_o = wr_i && !locked_q && (wdata_i[2:0] != 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= ctrl_t'(RST_VAL);
      locked_q <= 1'b0;
    end else if (wr_i && !locked_q) begin
      ctrl_q   <= ctrl_t'(wdata_i);
      locked_q <= 1'b1;
    end
  end

  p_write_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && locked_q) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdog_win_cnt.sv
module wdog_win_cnt
  import wdog_win_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 12
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctrl_i,
  input  logic  start_i,
  input  logic  restart_i,
  input  logic  halt_i,
  output logic  expire_o,
  output logic  win_open_o
);
  localparam int unsigned CW = BASE_SHIFT + 15;

  logic [CW-1:0] cnt_q, period, thr;
  logic          en, hold;

  assign en     = ctrl_i.rate != 3'd0;
  assign hold   = ctrl_i.frz && halt_i;
  assign period = CW'(1) << (BASE_SHIFT + 2 * int'(ctrl_i.rate));
  assign thr    = period - (period >> 2);

  assign expire_o   = en && !hold && (cnt_q == period - CW'(1));
  assign win_open_o = en && (!ctrl_i.win || cnt_q >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i || restart_i) cnt_q <= '0;
    else if (en && !hold)       cnt_q <= expire_o ? '0 : cnt_q + CW'(1);
  end

  p_restart_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
  p_freeze_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && hold && !start_i && !restart_i) |=> $stable(cnt_q));
  p_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |-> (cnt_q < period));
endmodule

// File: rtl/wdog_win_seq.sv
module wdog_win_seq
  import wdog_win_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       win_open_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       clear_i,
  output logic       service_o,
  output logic       fault_o
);
  logic armed_q, act, is_open, is_close;

  assign act      = en_i && wr_i;
  assign is_open  = wdata_i == KEY_OPEN;
  assign is_close = wdata_i == KEY_CLOSE;

  assign service_o = act && win_open_i && is_close && armed_q;
  assign fault_o   = act && (!win_open_i || !(is_open || (is_close && armed_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              armed_q <= 1'b0;
    else if (fault_o || service_o || clear_i) armed_q <= 1'b0;
    else if (act && win_open_i && is_open)    armed_q <= 1'b1;
  end

  p_seq_consumed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    service_o |=> !armed_q);
  p_idle_no_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !armed_q) |=> !armed_q);
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_win_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 12,
  parameter logic [4:0]  CTRL_RST   = 5'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       dbg_halt_i,
  output logic       rst_req_o,
  output logic       win_open_o
);
  ctrl_t ctrl;
  logic  start, expire, service, fault, ctrl_wr, arm_wr, en, rst_req_q;

  assign ctrl_wr = wr_en_i && (addr_i == SEL_CTRL);
  assign arm_wr  = wr_en_i && (addr_i == SEL_ARM);
  assign en      = ctrl.rate != 3'd0;

  wdog_win_ctrl #(.RST_VAL(CTRL_RST)) i_ctrl (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .wdata_i(wdata_i[4:0]),
    .ctrl_o(ctrl), .start_o(start)
  );

  wdog_win_cnt #(.BASE_SHIFT(BASE_SHIFT)) i_cnt (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .start_i(start),
    .restart_i(service || fault), .halt_i(dbg_halt_i),
    .expire_o(expire), .win_open_o(win_open_o)
  );

  wdog_win_seq i_seq (
    .clk_i, .rst_ni, .en_i(en), .win_open_i(win_open_o), .wr_i(arm_wr),
    .wdata_i, .clear_i(expire), .service_o(service), .fault_o(fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire || fault;
  end

  assign rst_req_o = rst_req_q;
  assign rdata_o   = (addr_i == SEL_CTRL) ? {3'b000, ctrl} : 8'h00;

  p_quiet_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !rst_req_o);
  p_early_arm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_wr && en && ctrl.win && !win_open_o) |=> rst_req_o);
  p_bad_key_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_wr && en && wdata_i != KEY_OPEN && wdata_i != KEY_CLOSE) |=> rst_req_o);
endmodule

// File: tb/test_wdog_win.sv
`timescale 1ns/1ps
module test_wdog_win;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       halt = 1'b0;
  logic [7:0] rdata;
  logic       rst_req, win_open;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  wdog_win #(.BASE_SHIFT(2)) i_wdog_win (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dbg_halt_i(halt),
    .rst_req_o(rst_req), .win_open_o(win_open)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; halt = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // expects rst_req low for k-1 samples, high at k, low at k+1
  task automatic expect_timeout(string req, int k);
    int early = 0;
    for (int i = 1; i < k; i++) begin
      @(negedge clk); if (rst_req) early++;
    end
    chk(req, early, 0);
    @(negedge clk); chk(req, rst_req, 1);
    @(negedge clk); chk(req, rst_req, 0);
  endtask

  task automatic t_reset();
    do_reset();
    addr = 1'b0; #1;
    chk("R11", rdata, 8'h00);
    chk("R11", rst_req, 0);
    chk("R3", win_open, 0);
  endtask

  task automatic t_disabled();
    int hits = 0;
    do_reset();
    wr(1'b1, 8'h12); wr(1'b1, 8'hAA);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (rst_req || win_open) hits++;
    end
    chk("R3", hits, 0);
  endtask

  task automatic t_layout();
    do_reset();
    wr(1'b0, 8'hFB);
    addr = 1'b0; #1; chk("R1", rdata, 8'h1B);
    addr = 1'b1; #1; chk("R1", rdata, 8'h00);
    addr = 1'b0;
    wr(1'b0, 8'h01);
    #1; chk("R2", rdata, 8'h1B);
  endtask

  task automatic t_timeout();
    do_reset();
    wr(1'b0, 8'h01);
    expect_timeout("R4", 16);
    do_reset();
    wr(1'b0, 8'h02);
    expect_timeout("R4", 64);
  endtask

  task automatic t_service();
    do_reset();
    wr(1'b0, 8'h02);
    idle(50);
    wr(1'b1, 8'h55);
    chk("R5", rst_req, 0);
    wr(1'b1, 8'hAA);
    chk("R5", rst_req, 0);
    expect_timeout("R5", 64);
  endtask

  task automatic t_badkey();
    do_reset();
    wr(1'b0, 8'h02); idle(3);
    wr(1'b1, 8'h33);
    chk("R6", rst_req, 1);
    do_reset();
    wr(1'b0, 8'h02); idle(3);
    wr(1'b1, 8'hAA);
    chk("R6", rst_req, 1);
  endtask

  task automatic t_window();
    do_reset();
    wr(1'b0, 8'h11);
    chk("R10", win_open, 0);
    idle(5);
    wr(1'b1, 8'h55);
    chk("R7", rst_req, 1);
    do_reset();
    wr(1'b0, 8'h11);
    idle(11); chk("R10", win_open, 0);
    idle(1);  chk("R10", win_open, 1);
    wr(1'b1, 8'h55); chk("R8", rst_req, 0);
    wr(1'b1, 8'h55); chk("R8", rst_req, 0);
    wr(1'b1, 8'hAA); chk("R8", rst_req, 0);
    chk("R10", win_open, 0);
    idle(3);
    wr(1'b1, 8'h55);
    chk("R7", rst_req, 1);
  endtask

  task automatic t_freeze();
    int hits = 0;
    do_reset();
    wr(1'b0, 8'h09);
    idle(5);
    halt = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (rst_req) hits++;
    end
    chk("R9", hits, 0);
    halt = 1'b0;
    expect_timeout("R9", 11);
    do_reset();
    halt = 1'b1;
    wr(1'b0, 8'h01);
    expect_timeout("R9", 16);
    halt = 1'b0;
  endtask

  task automatic t_reset_mid();
    do_reset();
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h55);
    do_reset();
    addr = 1'b0; #1; chk("R11", rdata, 8'h00);
    wr(1'b0, 8'h02);
    #1; chk("R11", rdata, 8'h02);
    wr(1'b1, 8'hAA);
    chk("R11", rst_req, 1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    report();
  end

  initial begin
    t_reset();
    t_disabled();
    t_layout();
    t_timeout();
    t_service();
    t_badkey();
    t_window();
    t_freeze();
    t_reset_mid();
    report();
  end
endmodule